// File: doc/BRIEF.md
# Programmable Crosspoint Routing Grid

This block is the switch fabric that joins a 3x3 field of logic-block ports and twelve I/O pins. Every source wire crosses every sink wire, and a single configuration bit sits at each crossing. A set bit closes the switch and joins the two wires. A clear bit leaves them apart, so each sink sees only the sources it was explicitly routed to. The sources are the nine logic-block outputs and the twelve I/O inputs. The sinks are two inputs per logic block and the twelve I/O outputs. Drive is resolved in one direction only: a sink carries the logical OR of every source that reaches it through a closed point. When a sink has more than one closed point, the configuration is flagged as a conflict, whatever values the sources carry.

Configuration arrives one bit per clock through a shift chain into a shadow store. The shadow store has no effect on routing. Routing changes only when a commit strobe copies the shadow store into the active store. This lets a new route be loaded in full while the previous one keeps working.

Top module: `xgrid_fabric`

## Requirements
- R1: After reset every crossing is open, every sink output reads 0 and `route_conflict` is 0, whatever the source inputs carry.
- R2: While `cfg_shift_en` is 1, each rising clock edge moves every shadow bit from index k to index k+1 and loads `cfg_bit` into index 0. After a full load, the first bit shifted in sits at the highest index.
- R3: Shadow contents do not alter the routing or the conflict flag until a commit. Outputs keep following the previously committed routing.
- R4: On a rising edge with `cfg_commit` at 1, the active store takes the shadow contents. The new routing is visible at the outputs right after that edge.
- R5: A closed crossing at index sink*21+src joins source src to sink sink. Source order is lb_out[0..8] as 0..8, then io_in[0..11] as 9..20. Sink order is lb_in[0..17] as 0..17, then io_out[0..11] as 18..29. Each sink equals the OR of all sources joined to it.
- R6: A sink with no closed crossing reads 0 for every source pattern. A source with no closed crossing reaches no sink.
- R7: `route_conflict` is 1 exactly when at least one sink has two or more closed crossings in the active store. It does not depend on source data.
- R8: If shift and commit happen in the same cycle, the active store takes the shadow contents from before that shift, and the shift still takes place.
- R9: While `cfg_shift_en` is 0, the shadow store holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shifts `cfg_bit` into the shadow chain |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copies the shadow store into the active store |
| lb_out | input | 9 | Logic-block output wires (sources) |
| io_in | input | 12 | I/O pin input wires (sources) |
| lb_in | output | 18 | Logic-block input wires, two per block (sinks) |
| io_out | output | 12 | I/O pin output wires (sinks) |
| route_conflict | output | 1 | Some sink has more than one closed crossing |

## Verification
A serial shift and a commit can fall on the same clock edge. The bench provokes this by holding both strobes high for one cycle after a full load. It then reads the outputs right away: they must still show the loaded route, which proves the pre-shift contents were captured. A second commit with no shift must then show every route moved by one source position, with a new closed point at index 0. This proves the shift also took place in that shared cycle.

// File: rtl/xgrid_pkg.sv
package xgrid_pkg;

   // Position of the crossing between a sink wire and a source wire
   function automatic int unsigned xg_index(input int unsigned sink,
                                            input int unsigned src,
                                            input int unsigned nsrc);
      return sink * nsrc + src;
   endfunction

endpackage

// File: rtl/xgrid_cfg_chain.sv
module xgrid_cfg_chain #(
   parameter int unsigned NBITS = 630
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic             commit,
   output logic [NBITS-1:0] shadow_q,
   output logic [NBITS-1:0] active_q
);

   if (NBITS < 2) begin : g_bad_nbits
      $error("xgrid_cfg_chain: NBITS must be at least 2");
   end

   // shadow store: serial load, new bit enters at index 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (shift_en) begin
         shadow_q <= {shadow_q[NBITS-2:0], bit_in};
      end
   end

   // active store: takes the pre-edge shadow value on commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (commit) begin
         active_q <= shadow_q;
      end
   end

endmodule

// File: rtl/xgrid_sink_node.sv
module xgrid_sink_node #(
   parameter int unsigned NSRC = 21
) (
   input  logic [NSRC-1:0] src_w,
   input  logic [NSRC-1:0] closed,
   output logic            sink_w,
   output logic            multi
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("xgrid_sink_node: NSRC must be at least 1");
   end

   assign sink_w = |(src_w & closed);

   // more than one set bit: clearing the lowest one leaves something
   assign multi = |(closed & (closed - NSRC'(1)));

endmodule

// File: rtl/xgrid_fabric.sv
module xgrid_fabric #(
   parameter int unsigned NUM_LB = 9,
   parameter int unsigned LB_INS = 2,
   parameter int unsigned NUM_IO = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_shift_en,
   input  logic                       cfg_bit,
   input  logic                       cfg_commit,
   input  logic [NUM_LB-1:0]          lb_out,
   input  logic [NUM_IO-1:0]          io_in,
   output logic [NUM_LB*LB_INS-1:0]   lb_in,
   output logic [NUM_IO-1:0]          io_out,
   output logic                       route_conflict
);
   import xgrid_pkg::*;

   localparam int unsigned NSRC  = NUM_LB + NUM_IO;
   localparam int unsigned NLBI  = NUM_LB * LB_INS;
   localparam int unsigned NSINK = NLBI + NUM_IO;
   localparam int unsigned NCFG  = NSRC * NSINK;

   if (NUM_LB < 1 || LB_INS < 1 || NUM_IO < 1) begin : g_bad_dims
      $error("xgrid_fabric: every port count must be at least 1");
   end
   if (NCFG > 4096) begin : g_bad_size
      $error("xgrid_fabric: crossing count exceeds 4096");
   end

   logic [NCFG-1:0]  cfg_shadow;
   logic [NCFG-1:0]  cfg_active;
   logic [NSRC-1:0]  src_bus;
   logic [NSINK-1:0] sink_bus;
   logic [NSINK-1:0] sink_multi;

   assign src_bus = {io_in, lb_out};

   xgrid_cfg_chain #(.NBITS(NCFG)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift_en),
      .bit_in   (cfg_bit),
      .commit   (cfg_commit),
      .shadow_q (cfg_shadow),
      .active_q (cfg_active)
   );

   for (genvar s = 0; s < NSINK; s++) begin : g_sink
      localparam int unsigned BASE = xg_index(s, 0, NSRC);
      xgrid_sink_node #(.NSRC(NSRC)) u_node (
         .src_w  (src_bus),
         .closed (cfg_active[BASE +: NSRC]),
         .sink_w (sink_bus[s]),
         .multi  (sink_multi[s])
      );
   end

   assign lb_in          = sink_bus[NLBI-1:0];
   assign io_out         = sink_bus[NSINK-1:NLBI];
   assign route_conflict = |sink_multi;

endmodule

// File: rtl/xgrid_fabric_chk.sv
module xgrid_fabric_chk #(
   parameter int unsigned NCFG = 630,
   parameter int unsigned NLBI = 18,
   parameter int unsigned NIO  = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_shift_en,
   input logic            cfg_bit,
   input logic            cfg_commit,
   input logic [NCFG-1:0] cfg_shadow,
   input logic [NCFG-1:0] cfg_active,
   input logic [NLBI-1:0] lb_in,
   input logic [NIO-1:0]  io_out,
   input logic            route_conflict
);

   // R1
   reset_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_active == '0));

   // R2
   shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift_en |=> (cfg_shadow == {$past(cfg_shadow[NCFG-2:0]), $past(cfg_bit)}));

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_shift_en |=> $stable(cfg_shadow));

   // R3
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_commit |=> $stable(cfg_active));

   // R4 and R8
   commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_commit |=> (cfg_active == $past(cfg_shadow)));

   // R6
   all_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active == '0) |-> (lb_in == '0 && io_out == '0));

   // R7
   conflict_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_conflict |-> ($countones(cfg_active) >= 2));

   // R7
   conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cfg_active) <= 1) |-> !route_conflict);

endmodule

bind xgrid_fabric xgrid_fabric_chk #(
   .NCFG (NCFG),
   .NLBI (NLBI),
   .NIO  (NUM_IO)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_shift_en   (cfg_shift_en),
   .cfg_bit        (cfg_bit),
   .cfg_commit     (cfg_commit),
   .cfg_shadow     (cfg_shadow),
   .cfg_active     (cfg_active),
   .lb_in          (lb_in),
   .io_out         (io_out),
   .route_conflict (route_conflict)
);

// File: tb/xgrid_fabric_bench.sv
module xgrid_fabric_bench;

   localparam int NSRC = 21;
   localparam int NSNK = 30;
   localparam int NCFG = NSRC * NSNK;

   typedef struct {
      string       tag;
      logic [11:0] io;
      logic [17:0] lb;
      logic        conf;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_shift_en = 1'b0;
   logic        cfg_bit = 1'b0;
   logic        cfg_commit = 1'b0;
   logic [8:0]  lb_out;
   logic [11:0] io_in = '0;
   logic [17:0] lb_in;
   logic [11:0] io_out;
   logic        route_conflict;
   logic        lb_fb = 1'b0;

   exp_t        sb_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   always #4 clk = ~clk;   // 125 MHz

   // model of logic block 0: registered copy of its second input
   always @(posedge clk) lb_fb <= lb_in[1];
   assign lb_out = {8'b0, lb_fb};

   xgrid_fabric u_xgrid_fabric (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_shift_en   (cfg_shift_en),
      .cfg_bit        (cfg_bit),
      .cfg_commit     (cfg_commit),
      .lb_out         (lb_out),
      .io_in          (io_in),
      .lb_in          (lb_in),
      .io_out         (io_out),
      .route_conflict (route_conflict)
   );

   // monitor: compares one expected item per falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (io_out !== e.io || lb_in !== e.lb || route_conflict !== e.conf) begin
            errors++;
            $display("FAIL %s: io_out=%h lb_in=%h conflict=%b expected io_out=%h lb_in=%h conflict=%b",
                     e.tag, io_out, lb_in, route_conflict, e.io, e.lb, e.conf);
         end
      end
   end

   function automatic int idx(input int sink, input int src);
      return sink * NSRC + src;
   endfunction

   // driver: applies a source pattern, lets the loop settle, queues the expectation
   task automatic probe(input string tag, input logic [11:0] pat,
                        input logic [11:0] eio, input logic [17:0] elb, input logic econf);
      exp_t e;
      @(posedge clk); #2;
      io_in = pat;
      @(posedge clk); #2;
      e.tag = tag; e.io = eio; e.lb = elb; e.conf = econf;
      sb_q.push_back(e);
   endtask

   task automatic load(input logic [NCFG-1:0] v);
      for (int i = NCFG - 1; i >= 0; i--) begin
         @(posedge clk); #2;
         cfg_shift_en = 1'b1;
         cfg_bit      = v[i];
      end
      @(posedge clk); #2;
      cfg_shift_en = 1'b0;
      cfg_bit      = 1'b0;
   endtask

   task automatic commit();
      @(posedge clk); #2;
      cfg_commit = 1'b1;
      @(posedge clk); #2;
      cfg_commit = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NCFG-1:0] cfg_a;
      logic [NCFG-1:0] cfg_b;
      cfg_a = '0;
      cfg_a[idx(1, 9)]  = 1'b1;   // io_in[0] -> lb_in[1]
      cfg_a[idx(23, 0)] = 1'b1;   // lb_out[0] -> io_out[5]
      cfg_b = '0;
      cfg_b[idx(25, 10)] = 1'b1;  // io_in[1] -> io_out[7]
      cfg_b[idx(25, 11)] = 1'b1;  // io_in[2] -> io_out[7]

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state, sources active
      probe("R1 reset all open", 12'hFFF, 12'h000, 18'h0, 1'b0);

      // R3: loaded but not committed
      load(cfg_a);
      probe("R3 uncommitted load", 12'h001, 12'h000, 18'h0, 1'b0);

      // R4 R5: route io0 -> LB0 -> io5
      commit();
      probe("R4 R5 route high", 12'h001, 12'h020, 18'h2, 1'b0);
      probe("R5 route low", 12'h000, 12'h000, 18'h0, 1'b0);
      // R6: other pins isolated
      probe("R6 unrouted pins", 12'hFFE, 12'h000, 18'h0, 1'b0);
      probe("R5 R6 all high", 12'hFFF, 12'h020, 18'h2, 1'b0);

      // R3: shadow replaced, active keeps the old route
      load(cfg_b);
      probe("R3 old route kept", 12'h001, 12'h020, 18'h2, 1'b0);

      // R7 R5: two drivers on io_out[7]
      commit();
      probe("R7 conflict io1", 12'h002, 12'h080, 18'h0, 1'b1);
      probe("R7 conflict io2", 12'h004, 12'h080, 18'h0, 1'b1);
      probe("R5 OR both", 12'h006, 12'h080, 18'h0, 1'b1);
      probe("R7 conflict idle", 12'h000, 12'h000, 18'h0, 1'b1);
      probe("R6 old route gone", 12'h001, 12'h000, 18'h0, 1'b1);

      // R8: shift and commit in the same cycle
      @(posedge clk); #2;
      cfg_shift_en = 1'b1; cfg_bit = 1'b1; cfg_commit = 1'b1;
      @(posedge clk); #2;
      cfg_shift_en = 1'b0; cfg_bit = 1'b0; cfg_commit = 1'b0;
      probe("R8 pre-shift captured", 12'h002, 12'h080, 18'h0, 1'b1);
      // R2 R8 R9: second commit shows the shifted chain
      commit();
      probe("R2 R8 shifted io1 dropped", 12'h002, 12'h000, 18'h0, 1'b1);
      probe("R2 R8 shifted io3", 12'h008, 12'h080, 18'h0, 1'b1);
      probe("R9 shifted io2", 12'h004, 12'h080, 18'h0, 1'b1);

      // R6 R7: empty routing
      load('0);
      commit();
      probe("R6 R7 cleared", 12'hFFF, 12'h000, 18'h0, 1'b0);

      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule